// File: doc/BRIEF.md
# Microcoded Operate Unit

This block executes the operate class of instructions for a 12-bit accumulator machine. It holds the accumulator and a one-bit link (carry) flag. When the execute strobe is high and the instruction carries the operate opcode, each set bit of the word enables one elementary action: clearing, complementing, incrementing, rotating or testing. The enabled actions run in a fixed order, so several bits in one word compose into useful results, such as loading small constants in a single instruction.

Instruction fetch, memory and the program counter are outside the block. Conditional execution is reported only as a skip request: a registered one-cycle pulse that tells the sequencer to step over the next instruction.

Bit numbering in this document follows the machine's convention: bit 0 is the most significant bit of the instruction word (port bit 11) and bit 11 is the least significant (port bit 0). A small state machine produces the skip pulse. It has two states. `ST_IDLE` means no skip is requested. `ST_SKIP` means a skip is requested in this cycle. The transition IDLE->SKIP or SKIP->SKIP ("take") happens on a clock edge where a group-2 instruction is executed and its condition holds. Every other edge goes to IDLE ("drop").

Top module: `opr_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the accumulator is 0, the link is 0 and the skip output is 0.
- R2: On an edge where the strobe is low, or where the opcode (bits 0 to 2) is not octal 7, the accumulator and link keep their values and no skip follows.
- R3: Bit 4 (clear accumulator) clears the accumulator in all three groups. It is applied before every other action. In group 2 the skip condition is evaluated on the accumulator value before the clear.
- R4: In group 1 (bit 3 = 0) the order of actions is: clear accumulator and clear link; then complement accumulator and complement link; then increment; then rotate. Word octal 7301 leaves the accumulator at 1 and the link at 0. Word octal 7305 leaves the accumulator at 2.
- R5: In group 1, bit 5 clears the link, bit 6 complements the accumulator and bit 7 complements the link.
- R6: In group 1, bit 11 increments the accumulator modulo 4096. A carry out of the top bit complements the link.
- R7: In group 1, bit 9 rotates left and bit 8 rotates right, both through the 13-bit ring formed by the link and the accumulator. Bit 10 makes the rotate two positions. If both direction bits are set, no rotate takes place. Bit 10 without a direction bit has no effect.
- R8: Group 2 (bit 3 = 1, bit 11 = 0) tests three conditions: bit 5 tests accumulator bit 0 set, bit 6 tests accumulator zero, and bit 7 tests link set. Without bit 8 the skip is the OR of the selected conditions. With bit 8 the skip is the AND of their negations, so bit 8 alone always skips. Group 2 never changes the link, and bits 9 and 10 have no effect.
- R9: Group 3 (bit 3 = 1, bit 11 = 1) applies only the clear of bit 4. The link is unchanged and no skip follows.
- R10: The skip output is high for exactly the one cycle after the edge that executed a skipping group-2 word. Two such words on consecutive edges keep it high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Execute strobe; the word on instr_i is executed at this edge |
| instr_i | input | 12 | Instruction word; port bit 11 is machine bit 0 |
| acc_o | output | 12 | Accumulator |
| link_o | output | 1 | Link flag |
| skip_o | output | 1 | One-cycle request to step over the next instruction |

## Verification
All state in the block is visible at the ports on the cycle after the edge that wrote it. A wrong accumulator, link or skip-state value therefore shows up at the next sample, with no latency to hide it. Ordering faults, such as an increment applied after the rotate or a skip test that reads the cleared accumulator, only appear for particular bit combinations. For that reason the bench combines directed combined-bit words with a long run of random operate words, all checked against an independent ring-arithmetic model on every cycle. A stuck or lingering skip state is caught on the very next idle cycle.

// File: rtl/opr_pkg.sv
package opr_pkg;

    // Opcode value of the operate class (machine bits 0..2)
    localparam logic [2:0] OPR_OPCODE = 3'b111;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_ONE,
        GRP_TWO,
        GRP_THREE
    } opr_group_e;

    typedef enum logic {
        ST_IDLE,
        ST_SKIP
    } skip_state_e;

    typedef struct packed {
        opr_group_e grp;
        logic       clr_acc;
        logic       clr_lnk;
        logic       inv_acc;
        logic       inv_lnk;
        logic       incr;
        logic       rot_lft;
        logic       rot_rgt;
        logic       rot_dbl;
        logic       tst_neg;
        logic       tst_zero;
        logic       tst_lnk;
        logic       tst_rev;
    } opr_ctl_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] instr_i,
    output opr_ctl_t          ctl_o
);
    // machine bit n sits at port index WORD_W-1-n
    localparam int P0  = WORD_W - 1;
    localparam int P3  = WORD_W - 1 - 3;
    localparam int P4  = WORD_W - 1 - 4;
    localparam int P5  = WORD_W - 1 - 5;
    localparam int P6  = WORD_W - 1 - 6;
    localparam int P7  = WORD_W - 1 - 7;
    localparam int P8  = WORD_W - 1 - 8;
    localparam int P9  = WORD_W - 1 - 9;
    localparam int P10 = WORD_W - 1 - 10;
    localparam int P11 = WORD_W - 1 - 11;

    logic       is_opr;
    opr_group_e grp;

    assign is_opr = (instr_i[P0 -: 3] == OPR_OPCODE);

    always_comb begin
        if (!is_opr)
            grp = GRP_NONE;
        else if (!instr_i[P3])
            grp = GRP_ONE;
        else if (!instr_i[P11])
            grp = GRP_TWO;
        else
            grp = GRP_THREE;
    end

    always_comb begin
        ctl_o          = '0;
        ctl_o.grp      = grp;
        ctl_o.clr_acc  = is_opr && instr_i[P4];
        unique case (grp)
            GRP_ONE: begin
                ctl_o.clr_lnk = instr_i[P5];
                ctl_o.inv_acc = instr_i[P6];
                ctl_o.inv_lnk = instr_i[P7];
                ctl_o.rot_rgt = instr_i[P8];
                ctl_o.rot_lft = instr_i[P9];
                ctl_o.rot_dbl = instr_i[P10];
                ctl_o.incr    = instr_i[P11];
            end
            GRP_TWO: begin
                ctl_o.tst_neg  = instr_i[P5];
                ctl_o.tst_zero = instr_i[P6];
                ctl_o.tst_lnk  = instr_i[P7];
                ctl_o.tst_rev  = instr_i[P8];
            end
            GRP_THREE, GRP_NONE: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/opr_arith_path.sv
module opr_arith_path
    import opr_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int ROT_MAX = 2
) (
    input  opr_ctl_t          ctl_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              lnk_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              lnk_o
);
    localparam int RING_W = WORD_W + 1;

    logic [WORD_W-1:0] s1_acc, s2_acc, s3_acc;
    logic              s1_lnk, s2_lnk, s3_lnk;
    logic              carry;
    logic              rot_en;
    logic [RING_W-1:0] ring [ROT_MAX+1];

    // step 1: clears
    always_comb begin
        s1_acc = ctl_i.clr_acc ? '0 : acc_i;
        s1_lnk = ctl_i.clr_lnk ? 1'b0 : lnk_i;
    end

    // step 2: complements
    always_comb begin
        s2_acc = ctl_i.inv_acc ? ~s1_acc : s1_acc;
        s2_lnk = ctl_i.inv_lnk ? ~s1_lnk : s1_lnk;
    end

    // step 3: increment; carry out flips the link
    always_comb begin
        {carry, s3_acc} = {1'b0, s2_acc} + {{WORD_W{1'b0}}, ctl_i.incr};
        s3_lnk          = s2_lnk ^ carry;
    end

    // step 4: rotate through the {link, acc} ring
    assign rot_en  = ctl_i.rot_lft ^ ctl_i.rot_rgt;
    assign ring[0] = {s3_lnk, s3_acc};

    for (genvar k = 0; k < ROT_MAX; k++) begin : g_rot_stage
        logic active;
        assign active = rot_en && ((k == 0) || ctl_i.rot_dbl);
        always_comb begin
            if (!active)
                ring[k+1] = ring[k];
            else if (ctl_i.rot_lft)
                ring[k+1] = {ring[k][RING_W-2:0], ring[k][RING_W-1]};
            else
                ring[k+1] = {ring[k][0], ring[k][RING_W-1:1]};
        end
    end

    assign lnk_o = ring[ROT_MAX][RING_W-1];
    assign acc_o = ring[ROT_MAX][WORD_W-1:0];

endmodule

// File: rtl/opr_skip_eval.sv
module opr_skip_eval
    import opr_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  opr_ctl_t          ctl_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              lnk_i,
    output logic              skip_o
);
    logic any_hit;

    always_comb begin
        any_hit = (ctl_i.tst_neg  && acc_i[WORD_W-1])
               || (ctl_i.tst_zero && (acc_i == '0))
               || (ctl_i.tst_lnk  && lnk_i);
        skip_o  = (ctl_i.grp == GRP_TWO) && (ctl_i.tst_rev ? !any_hit : any_hit);
    end

endmodule

// File: rtl/opr_unit.sv
module opr_unit
    import opr_pkg::*;
#(
    parameter int WORD_W  = 12,
    parameter int ROT_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [WORD_W-1:0] instr_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              link_o,
    output logic              skip_o
);
    opr_ctl_t          ctl;
    logic [WORD_W-1:0] acc_q, acc_d, g1_acc;
    logic              lnk_q, lnk_d, g1_lnk;
    logic              skip_hit;
    skip_state_e       state_q, state_d;

    opr_decode #(.WORD_W(WORD_W)) u_decode (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    opr_arith_path #(.WORD_W(WORD_W), .ROT_MAX(ROT_MAX)) u_arith (
        .ctl_i (ctl),
        .acc_i (acc_q),
        .lnk_i (lnk_q),
        .acc_o (g1_acc),
        .lnk_o (g1_lnk)
    );

    opr_skip_eval #(.WORD_W(WORD_W)) u_skip (
        .ctl_i  (ctl),
        .acc_i  (acc_q),
        .lnk_i  (lnk_q),
        .skip_o (skip_hit)
    );

    // next accumulator and link by group
    always_comb begin
        acc_d = acc_q;
        lnk_d = lnk_q;
        if (exec_en) begin
            unique case (ctl.grp)
                GRP_ONE: begin
                    acc_d = g1_acc;
                    lnk_d = g1_lnk;
                end
                GRP_TWO, GRP_THREE: begin
                    if (ctl.clr_acc)
                        acc_d = '0;
                end
                GRP_NONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // next skip state: take or drop
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = (exec_en && skip_hit) ? ST_SKIP : ST_IDLE;
            ST_SKIP: state_d = (exec_en && skip_hit) ? ST_SKIP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            lnk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            lnk_q   <= lnk_d;
        end
    end

    // outputs
    always_comb begin
        acc_o  = acc_q;
        link_o = lnk_q;
        skip_o = (state_q == ST_SKIP);
    end

    // ---------------- assertions ----------------
    logic g2_exec, g3_exec, g1_clear_only;
    assign g2_exec = exec_en && (ctl.grp == GRP_TWO);
    assign g3_exec = exec_en && (ctl.grp == GRP_THREE);
    assign g1_clear_only = exec_en && (ctl.grp == GRP_ONE) && ctl.clr_acc
                        && !ctl.inv_acc && !ctl.incr && !ctl.rot_lft && !ctl.rot_rgt;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(acc_o) && $stable(link_o) && !skip_o));

    p_clear_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        g1_clear_only |=> (acc_o == '0));

    p_const_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && instr_i == WORD_W'(12'o7301)) |=> (acc_o == WORD_W'(1) && !link_o));

    p_grp2_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
        g2_exec |=> $stable(link_o));

    p_grp3_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        g3_exec |=> ($stable(link_o) && !skip_o));

    p_skip_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> $past(g2_exec));

endmodule

// File: tb/tb_opr_unit.sv
`timescale 1ns/1ps
module tb_opr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [11:0] instr_i = '0;
    logic [11:0] acc_o;
    logic        link_o;
    logic        skip_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_ac = 0;
    int m_l = 0;
    int m_skip = 0;

    always #2.5 clk = ~clk;

    opr_unit dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .instr_i (instr_i),
        .acc_o   (acc_o),
        .link_o  (link_o),
        .skip_o  (skip_o)
    );

    function automatic int mb(input logic [11:0] w, input int n);
        return int'(w[11-n]);
    endfunction

    // behavioural reference: integer ring arithmetic
    task automatic model(input logic e, input logic [11:0] w);
        int ring, cnt, cond;
        m_skip = 0;
        if (!e || w[11:9] != 3'b111) return;
        if (mb(w,3) == 0) begin
            if (mb(w,4)) m_ac = 0;
            if (mb(w,5)) m_l = 0;
            if (mb(w,6)) m_ac = 4095 - m_ac;
            if (mb(w,7)) m_l = 1 - m_l;
            if (mb(w,11)) begin
                m_ac = m_ac + 1;
                if (m_ac == 4096) begin m_ac = 0; m_l = 1 - m_l; end
            end
            if (mb(w,8) != mb(w,9)) begin
                cnt = mb(w,10) ? 2 : 1;
                ring = m_l * 4096 + m_ac;
                for (int i = 0; i < cnt; i++) begin
                    if (mb(w,9)) ring = ((ring * 2) % 8192) + (ring / 4096);
                    else         ring = (ring / 2) + (ring % 2) * 4096;
                end
                m_l = ring / 4096;
                m_ac = ring % 4096;
            end
        end else if (mb(w,11) == 0) begin
            cond = 0;
            if (mb(w,5) && m_ac >= 2048) cond = 1;
            if (mb(w,6) && m_ac == 0)    cond = 1;
            if (mb(w,7) && m_l == 1)     cond = 1;
            m_skip = mb(w,8) ? 1 - cond : cond;
            if (mb(w,4)) m_ac = 0;
        end else begin
            if (mb(w,4)) m_ac = 0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(acc_o) != m_ac) begin
            errors++;
            $display("FAIL %s acc actual=%o expected=%o", tag, acc_o, m_ac);
        end
        checks++;
        if (int'(link_o) != m_l) begin
            errors++;
            $display("FAIL %s link actual=%0d expected=%0d", tag, link_o, m_l);
        end
        checks++;
        if (int'(skip_o) != m_skip) begin
            errors++;
            $display("FAIL %s skip actual=%0d expected=%0d", tag, skip_o, m_skip);
        end
    endtask

    // called at a negative edge: drive, let one edge pass, compare
    task automatic step(input logic e, input logic [11:0] w, input string tag);
        exec_en = e;
        instr_i = w;
        model(e, w);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic string tag_of(input logic [11:0] w);
        if (w[11:9] != 3'b111) return "R2 non-operate";
        if (!w[8]) return "R4 group1";
        if (!w[0]) return "R8 group2";
        return "R9 group3";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        step(1'b0, 12'o0000, "R1 after reset");

        // constants by composition
        step(1'b1, 12'o7301, "R4 CLA CLL IAC");
        step(1'b1, 12'o7305, "R4 CLA CLL IAC RAL");
        // field actions
        step(1'b1, 12'o7240, "R5 CLA CMA");
        step(1'b1, 12'o7001, "R6 increment wrap");
        step(1'b1, 12'o7020, "R5 complement link");
        step(1'b1, 12'o7020, "R5 complement link again");
        step(1'b1, 12'o7100, "R5 clear link");
        // rotates
        step(1'b1, 12'o7201, "R7 load one");
        step(1'b1, 12'o7012, "R7 rotate right twice");
        step(1'b1, 12'o7010, "R7 rotate right");
        step(1'b1, 12'o7006, "R7 rotate left twice");
        step(1'b1, 12'o7016, "R7 both directions");
        step(1'b1, 12'o7002, "R7 double alone");
        // skips
        step(1'b1, 12'o7200, "R3 clear");
        step(1'b1, 12'o7500, "R8 SMA zero acc");
        step(1'b1, 12'o7440, "R8 SZA zero acc");
        step(1'b0, 12'o7440, "R10 pulse ends");
        step(1'b1, 12'o7240, "R5 all ones");
        step(1'b1, 12'o7640, "R3 SZA CLA uses old acc");
        step(1'b1, 12'o7650, "R3 SNA CLA");
        step(1'b1, 12'o7410, "R8 reverse alone");
        step(1'b1, 12'o7410, "R10 back to back");
        step(1'b1, 12'o7020, "R10 drop after two");
        step(1'b1, 12'o7426, "R8 SNL with ignored bits");
        step(1'b1, 12'o7530, "R8 reverse SMA SNL");
        // group 3 and non-operate
        step(1'b1, 12'o7040, "R5 complement acc");
        step(1'b1, 12'o7521, "R9 group3 no clear");
        step(1'b1, 12'o7601, "R9 group3 clear");
        step(1'b1, 12'o7041, "R6 negate");
        step(1'b1, 12'o1234, "R2 other opcode");
        step(1'b0, 12'o7200, "R2 strobe low");
        step(1'b1, 12'o6440, "R2 other opcode skip bits");

        // random operate words
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] w;
            logic e;
            w = 12'($urandom);
            if (($urandom % 8) != 0) w[11:9] = 3'b111;
            e = (($urandom % 5) != 0);
            step(e, w, e ? tag_of(w) : "R2 idle");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule